// File: doc/BRIEF.md
# Burst Column Address Generator

This block holds the burst-mode settings of a synchronous DRAM and turns a
read or write command into a stream of column addresses, one per clock. A
mode-set command loads the burst length, the wrap order, the CAS latency and
the write-burst policy from the address bus. Codes that are not defined are
rejected and flagged, and the old settings stay in place.

A read or write command supplies an 8-bit starting column. The block then
walks through an aligned block of columns whose size is the burst length.
The walk is either a plain increment that wraps inside the block, or the
start column XORed with the beat number. In full-page mode it steps through
all 256 columns and keeps wrapping until a stop or a new command ends it. A
one-cycle flag marks the final column of every bounded burst. The data path,
byte masking and the array are handled elsewhere.

Top module: `burst_colgen`

## Requirements
- R1: After reset, no burst is active, `col_last` and `mode_err` are 0, and the settings read length code 000 (one beat), sequential order, `cfg_cl` = 2 and `cfg_single_wr` = 0.
- R2: A mode-set command with a legal code updates the settings, visible the next cycle. The fields are: `addr[2:0]` length code (000=1, 001=2, 010=4, 011=8, 111=full page), `addr[3]` order (0 sequential, 1 interleave), `addr[6:4]` latency code (001, 010, 011, shown on `cfg_cl` as 1, 2, 3) and `addr[9]` single-write policy.
- R3: A mode-set command is rejected when the length code is 100, 101 or 110, when code 111 comes with `addr[3]`=1, or when the latency code is 000 or 1xx. A rejected command raises `mode_err` for the next cycle and leaves every `cfg_*` output unchanged.
- R4: In the cycle after a read or write command, `col_valid` is 1, `col_addr` equals the command's `addr[7:0]`, and `col_write` is 1 for a write and 0 for a read.
- R5: In sequential order, each beat keeps the column bits above the block size and adds one to the bits within it, modulo the burst length. For example, start 0x05 with length 8 gives 05,06,07,00,01,02,03,04.
- R6: In interleave order, beat i produces the start column XOR i. For example, start 0x03 with length 4 gives 03,02,01,00.
- R7: `col_last` is 1 exactly on the final beat of a bounded burst. Unless a new read or write arrives on that cycle, `col_valid` is 0 from the next cycle on.
- R8: A full-page burst produces the start column plus i modulo 256. It never raises `col_last`, and it keeps running past 256 beats.
- R9: A stop command ends the burst, and `col_valid` is 0 the next cycle. A read or write given in the same cycle as a stop takes priority and starts a burst.
- R10: A read or write issued during a burst restarts the generator at the new column on the next beat and runs the full new length.
- R11: With single-write set, a write burst is one beat long with `col_last` set, whatever the programmed length. Reads still use the programmed length, and with single-write clear, writes do too.
- R12: A burst keeps the length and order that were in force when it started. A mode-set command issued during the burst does not change it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_mrs | input | 1 | Mode-set command |
| cmd_rd | input | 1 | Read command |
| cmd_wr | input | 1 | Write command |
| cmd_stop | input | 1 | Burst stop command |
| addr | input | ADDR_W | Address bus: mode fields or start column |
| col_valid | output | 1 | A burst column is presented |
| col_addr | output | 8 | Current column |
| col_last | output | 1 | Final beat of a bounded burst |
| col_write | output | 1 | Current burst is a write |
| cfg_bl | output | 3 | Stored length code |
| cfg_ilv | output | 1 | Stored order, 1 = interleave |
| cfg_cl | output | 2 | Stored CAS latency, 1 to 3 |
| cfg_single_wr | output | 1 | Stored single-write policy |
| mode_err | output | 1 | Previous mode-set command was rejected |

## Verification
The bound checker checks these properties on every cycle: the first column follows its command, a sequential beat moves by one inside its block, an interleaved beat stays within its aligned block, and a stop or final beat ends the burst. It also checks that full-page bursts never flag a last beat, that a single-beat write ends at once, and that a rejected mode-set command leaves the settings unchanged. Only the directed scenarios can show the exact order of columns against an independent model. The same holds for the positions of the last beat across lengths and wrap points, for a restart in mid-burst, and for a mode change that lands while a burst is running.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  localparam int COL_W = 8;
  typedef logic [COL_W-1:0] col_t;
  localparam logic [2:0] BL_FULL = 3'b111;

  // legal length codes: 1, 2, 4, 8 beats or a whole page
  function automatic logic bl_code_ok(input logic [2:0] c);
    return (c[2] == 1'b0) || (c == BL_FULL);
  endfunction

  // legal latency codes: 1 to 3
  function automatic logic cl_code_ok(input logic [2:0] c);
    return (c[2] == 1'b0) && (c[1:0] != 2'b00);
  endfunction

  function automatic logic mode_ok(input logic [2:0] bl, input logic ilv,
                                   input logic [2:0] cl);
    return bl_code_ok(bl) && cl_code_ok(cl) && !((bl == BL_FULL) && ilv);
  endfunction

  // wrap mask: burst length minus one
  function automatic col_t bl_mask(input logic [2:0] c);
    case (c)
      3'd0:    return '0;
      3'd1:    return col_t'(1);
      3'd2:    return col_t'(3);
      3'd3:    return col_t'(7);
      default: return '1;
    endcase
  endfunction

  // column of a given beat inside the aligned block
  function automatic col_t burst_col(input col_t st, input col_t beat,
                                     input col_t mask, input logic ilv);
    col_t seq;
    seq = (st & ~mask) | ((st + beat) & mask);
    return ilv ? (st ^ beat) : seq;
  endfunction
endpackage

// File: rtl/bcg_mode_reg.sv
module bcg_mode_reg
  import bcg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] bl_in,
  input  logic       ilv_in,
  input  logic [2:0] cl_in,
  input  logic       sw_in,
  output logic [2:0] bl_q,
  output logic       ilv_q,
  output logic [1:0] cl_q,
  output logic       sw_q,
  output logic       err_q
);
  logic legal;
  assign legal = mode_ok(bl_in, ilv_in, cl_in);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bl_q  <= 3'd0;
      ilv_q <= 1'b0;
      cl_q  <= 2'd2;
      sw_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      err_q <= wr_en && !legal;
      if (wr_en && legal) begin
        bl_q  <= bl_in;
        ilv_q <= ilv_in;
        cl_q  <= cl_in[1:0];
        sw_q  <= sw_in;
      end
    end
  end
endmodule

// File: rtl/bcg_burst_ctr.sv
module bcg_burst_ctr
  import bcg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic go_wr,
  input  logic halt,
  input  col_t go_col,
  input  col_t go_mask,
  input  logic go_full,
  input  logic go_ilv,
  output logic valid,
  output col_t col,
  output logic last,
  output logic write,
  output col_t cur_mask,
  output logic cur_ilv,
  output logic cur_full
);
  logic active_q, wr_q, ilv_q, full_q;
  col_t start_q, beat_q, mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      wr_q     <= 1'b0;
      ilv_q    <= 1'b0;
      full_q   <= 1'b0;
      start_q  <= '0;
      beat_q   <= '0;
      mask_q   <= '0;
    end else if (go) begin
      active_q <= 1'b1;
      wr_q     <= go_wr;
      ilv_q    <= go_ilv;
      full_q   <= go_full;
      start_q  <= go_col;
      beat_q   <= '0;
      mask_q   <= go_mask;
    end else if (halt || last) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      beat_q   <= beat_q + col_t'(1);
    end
  end

  assign valid    = active_q;
  assign last     = active_q && !full_q && (beat_q == mask_q);
  assign col      = burst_col(start_q, beat_q, mask_q, ilv_q);
  assign write    = wr_q;
  assign cur_mask = mask_q;
  assign cur_ilv  = ilv_q;
  assign cur_full = full_q;
endmodule

// File: rtl/burst_colgen.sv
module burst_colgen #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_mrs,
  input  logic              cmd_rd,
  input  logic              cmd_wr,
  input  logic              cmd_stop,
  input  logic [ADDR_W-1:0] addr,
  output logic              col_valid,
  output logic [7:0]        col_addr,
  output logic              col_last,
  output logic              col_write,
  output logic [2:0]        cfg_bl,
  output logic              cfg_ilv,
  output logic [1:0]        cfg_cl,
  output logic              cfg_single_wr,
  output logic              mode_err
);
  import bcg_pkg::*;

  // named events for the checker
  logic start_evt, single_evt, burst_ilv, burst_full;
  col_t start_mask, burst_mask;

  assign start_evt  = cmd_rd || cmd_wr;
  assign single_evt = cmd_wr && cfg_single_wr;
  assign start_mask = single_evt ? '0 : bl_mask(cfg_bl);

  bcg_mode_reg u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cmd_mrs),
    .bl_in  (addr[2:0]),
    .ilv_in (addr[3]),
    .cl_in  (addr[6:4]),
    .sw_in  (addr[9]),
    .bl_q   (cfg_bl),
    .ilv_q  (cfg_ilv),
    .cl_q   (cfg_cl),
    .sw_q   (cfg_single_wr),
    .err_q  (mode_err)
  );

  bcg_burst_ctr u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (start_evt),
    .go_wr    (cmd_wr),
    .halt     (cmd_stop),
    .go_col   (addr[COL_W-1:0]),
    .go_mask  (start_mask),
    .go_full  (!single_evt && (cfg_bl == BL_FULL)),
    .go_ilv   (cfg_ilv),
    .valid    (col_valid),
    .col      (col_addr),
    .last     (col_last),
    .write    (col_write),
    .cur_mask (burst_mask),
    .cur_ilv  (burst_ilv),
    .cur_full (burst_full)
  );
endmodule

// File: rtl/bcg_chk.sv
module bcg_chk
  import bcg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_rd,
  input logic              cmd_wr,
  input logic              cmd_stop,
  input logic [ADDR_W-1:0] addr,
  input logic              col_valid,
  input col_t              col_addr,
  input logic              col_last,
  input logic              col_write,
  input logic [2:0]        cfg_bl,
  input logic              cfg_ilv,
  input logic [1:0]        cfg_cl,
  input logic              cfg_single_wr,
  input logic              mode_err,
  input col_t              burst_mask,
  input logic              burst_ilv,
  input logic              burst_full
);
  logic quiet;
  assign quiet = !cmd_rd && !cmd_wr && !cmd_stop;

  // R4
  start_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rd || cmd_wr) |=> col_valid && (col_addr == $past(addr[COL_W-1:0]))
                           && (col_write == $past(cmd_wr)));

  // R7
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid);

  // R7
  last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_last && !cmd_rd && !cmd_wr |=> !col_valid);

  // R9
  stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop && !cmd_rd && !cmd_wr |=> !col_valid);

  // R5
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && !col_last && quiet && !burst_ilv |=> col_valid
      && (((col_addr - $past(col_addr)) & $past(burst_mask)) == col_t'(1))
      && (((col_addr ^ $past(col_addr)) & ~$past(burst_mask)) == '0));

  // R6
  ilv_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && !col_last && quiet && burst_ilv |=> col_valid
      && (((col_addr ^ $past(col_addr)) & ~$past(burst_mask)) == '0));

  // R8
  full_no_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && burst_full |-> !col_last);

  // R3
  reject_keeps_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> $stable(cfg_bl) && $stable(cfg_ilv) && $stable(cfg_cl)
                 && $stable(cfg_single_wr));

  // R11
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && !cmd_rd && cfg_single_wr |=> col_last);
endmodule

bind burst_colgen bcg_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_rd        (cmd_rd),
  .cmd_wr        (cmd_wr),
  .cmd_stop      (cmd_stop),
  .addr          (addr),
  .col_valid     (col_valid),
  .col_addr      (col_addr),
  .col_last      (col_last),
  .col_write     (col_write),
  .cfg_bl        (cfg_bl),
  .cfg_ilv       (cfg_ilv),
  .cfg_cl        (cfg_cl),
  .cfg_single_wr (cfg_single_wr),
  .mode_err      (mode_err),
  .burst_mask    (burst_mask),
  .burst_ilv     (burst_ilv),
  .burst_full    (burst_full)
);

// File: tb/sim_burst_colgen.sv
module sim_burst_colgen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_mrs = 1'b0, cmd_rd = 1'b0, cmd_wr = 1'b0, cmd_stop = 1'b0;
  logic [11:0] addr = '0;
  logic        col_valid, col_last, col_write, cfg_ilv, cfg_single_wr, mode_err;
  logic [7:0]  col_addr;
  logic [2:0]  cfg_bl;
  logic [1:0]  cfg_cl;

  int n_chk = 0;
  int n_fail = 0;
  logic [2:0] e_bl = 3'd0;
  logic       e_ilv = 1'b0;
  logic [1:0] e_cl = 2'd2;
  logic       e_sw = 1'b0;

  always #4 clk = ~clk;

  burst_colgen #(.ADDR_W(12)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_mrs(cmd_mrs), .cmd_rd(cmd_rd),
    .cmd_wr(cmd_wr), .cmd_stop(cmd_stop), .addr(addr),
    .col_valid(col_valid), .col_addr(col_addr), .col_last(col_last),
    .col_write(col_write), .cfg_bl(cfg_bl), .cfg_ilv(cfg_ilv),
    .cfg_cl(cfg_cl), .cfg_single_wr(cfg_single_wr), .mode_err(mode_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_col(input int st, input int i, input int len, input bit ilv);
    if (ilv) return 8'(st ^ i);
    return 8'((st / len) * len + ((st % len) + i) % len);
  endfunction

  task automatic idle_cmds();
    cmd_mrs = 0; cmd_rd = 0; cmd_wr = 0; cmd_stop = 0;
  endtask

  task automatic chk_cfg(input string req);
    chk({req, " cfg_bl"}, 32'(cfg_bl), 32'(e_bl));
    chk({req, " cfg_ilv"}, 32'(cfg_ilv), 32'(e_ilv));
    chk({req, " cfg_cl"}, 32'(cfg_cl), 32'(e_cl));
    chk({req, " cfg_sw"}, 32'(cfg_single_wr), 32'(e_sw));
  endtask

  // mode-set; expected settings follow only a legal code
  task automatic mrs(input logic [11:0] a, input bit bad, input string req);
    @(negedge clk);
    idle_cmds(); cmd_mrs = 1; addr = a;
    @(negedge clk);
    idle_cmds();
    if (!bad) begin
      e_bl = a[2:0]; e_ilv = a[3]; e_cl = a[5:4]; e_sw = a[9];
    end
    chk({req, " mode_err"}, 32'(mode_err), 32'(bad));
    chk_cfg(req);
  endtask

  // issue a command and check every beat of a bounded burst
  task automatic burst(input logic [7:0] st, input bit wr, input int len,
                       input bit ilv, input string req);
    @(negedge clk);
    idle_cmds(); cmd_rd = !wr; cmd_wr = wr; addr = {4'h0, st};
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      idle_cmds();
      chk({req, " valid"}, 32'(col_valid), 1);
      chk({req, " col"}, 32'(col_addr), 32'(exp_col(st, i, len, ilv)));
      chk({req, " last"}, 32'(col_last), 32'(i == len - 1));
      chk({req, " write"}, 32'(col_write), 32'(wr));
    end
    @(negedge clk);
    chk({req, " ends"}, 32'(col_valid), 0);
  endtask

  task automatic t_reset();
    chk("R1 valid", 32'(col_valid), 0);
    chk("R1 last", 32'(col_last), 0);
    chk("R1 mode_err", 32'(mode_err), 0);
    chk_cfg("R1");
  endtask

  task automatic t_modes();
    mrs(12'h032, 0, "R2 len4 cl3");
    burst(8'h5E, 0, 4, 0, "R5 len4 wrap");
    mrs(12'h023, 0, "R2 len8 cl2");
    burst(8'h05, 0, 8, 0, "R5 len8 start5");
    burst(8'hA5, 1, 8, 0, "R11 write uses length");
    mrs(12'h021, 0, "R2 len2");
    burst(8'h41, 0, 2, 0, "R5 len2");
    mrs(12'h010, 0, "R2 len1 cl1");
    burst(8'h77, 0, 1, 0, "R7 single beat");
    mrs(12'h02B, 0, "R2 ilv8");
    burst(8'h03, 0, 8, 1, "R6 ilv8");
    mrs(12'h03A, 0, "R2 ilv4");
    burst(8'h13, 0, 4, 1, "R6 ilv4");
    burst(8'hC6, 0, 4, 1, "R6 ilv4 upper");
  endtask

  task automatic t_reserved();
    mrs(12'h024, 1, "R3 len100");
    mrs(12'h026, 1, "R3 len110");
    mrs(12'h02F, 1, "R3 full+ilv");
    mrs(12'h003, 1, "R3 cl000");
    mrs(12'h053, 1, "R3 cl101");
    @(negedge clk);
    chk("R3 pulse clears", 32'(mode_err), 0);
  endtask

  task automatic t_full();
    mrs(12'h027, 0, "R2 full page");
    @(negedge clk);
    idle_cmds(); cmd_rd = 1; addr = 12'h0FE;
    for (int i = 0; i < 260; i++) begin
      @(negedge clk);
      idle_cmds();
      chk("R8 col", 32'(col_addr), 32'((8'hFE + i) % 256));
      chk("R8 no last", 32'(col_last), 0);
    end
    cmd_stop = 1;
    @(negedge clk);
    idle_cmds();
    chk("R9 stop full", 32'(col_valid), 0);
  endtask

  task automatic t_stop();
    mrs(12'h023, 0, "R2 len8 again");
    @(negedge clk);
    idle_cmds(); cmd_rd = 1; addr = 12'h020;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      idle_cmds();
      chk("R9 pre-stop col", 32'(col_addr), 32'(8'h20 + i));
    end
    cmd_stop = 1;
    @(negedge clk);
    idle_cmds();
    chk("R9 stopped", 32'(col_valid), 0);
    cmd_rd = 1; cmd_stop = 1; addr = 12'h050;
    @(negedge clk);
    idle_cmds();
    chk("R9 read wins valid", 32'(col_valid), 1);
    chk("R9 read wins col", 32'(col_addr), 32'h50);
    cmd_stop = 1;
    @(negedge clk);
    idle_cmds();
    chk("R9 stop again", 32'(col_valid), 0);
  endtask

  task automatic t_restart();
    @(negedge clk);
    idle_cmds(); cmd_rd = 1; addr = 12'h010;
    @(negedge clk);
    idle_cmds();
    chk("R10 first", 32'(col_addr), 32'h10);
    @(negedge clk);
    chk("R10 second", 32'(col_addr), 32'h11);
    cmd_wr = 1; addr = 12'h036;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      idle_cmds();
      chk("R10 col", 32'(col_addr), 32'(exp_col(8'h36, i, 8, 0)));
      chk("R10 last", 32'(col_last), 32'(i == 7));
      chk("R10 write", 32'(col_write), 1);
    end
    @(negedge clk);
    chk("R10 ends", 32'(col_valid), 0);
  endtask

  task automatic t_single();
    mrs(12'h223, 0, "R2 single write");
    burst(8'h44, 1, 1, 0, "R11 write one beat");
    burst(8'h44, 0, 8, 0, "R11 read full length");
  endtask

  task automatic t_midmode();
    mrs(12'h023, 0, "R2 len8 plain");
    @(negedge clk);
    idle_cmds(); cmd_rd = 1; addr = 12'h00C;
    @(negedge clk);
    idle_cmds();
    chk("R12 beat0", 32'(col_addr), 32'h0C);
    cmd_mrs = 1; addr = 12'h02A;
    e_bl = 3'd2; e_ilv = 1'b1; e_cl = 2'd2; e_sw = 1'b0;
    for (int i = 1; i < 8; i++) begin
      @(negedge clk);
      idle_cmds();
      chk("R12 col", 32'(col_addr), 32'(exp_col(8'h0C, i, 8, 0)));
      chk("R12 last", 32'(col_last), 32'(i == 7));
    end
    chk_cfg("R12 new mode");
    @(negedge clk);
    chk("R12 ends", 32'(col_valid), 0);
  endtask

  initial begin
    #(8 * 20000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_modes();
    t_reserved();
    t_full();
    t_stop();
    t_restart();
    t_single();
    t_midmode();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule